// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Combined Operations

This is a purely combinational arithmetic and logic unit for a small 8-bit accumulator processor. A sequencer presents an operation code together with the accumulator, the X index register, an operand byte and the current flag vector. In the same evaluation, the unit returns three values and the updated flags:

- the new accumulator (or primary register) value;
- the byte to write back to memory for read-modify-write operations;
- the new X value.

The documented operations are add and subtract with carry, AND/OR/XOR, compare against A or X, bit test, the four shifts and rotates, and increment and decrement. The unit also provides the widely exploited undocumented combinations:

- operations that fuse a memory shift or step with an accumulator operation;
- AND followed by a carry copy;
- AND followed by a shift or a rotate;
- AND of A and X followed by a subtraction.

Flags that an operation does not define pass through unchanged. Decimal mode is not implemented. The decimal flag only travels through the unit.

Top module: `alu8_core`

## Requirements
- R1: Flag vectors are laid out as {N,V,D,Z,C} at bits 4..0. ADC forms A + operand + C as a nine-bit sum: res is the low byte and C is bit 8. V is set when A and the operand share a sign and the result's sign differs. N and Z follow the result.
- R2: SBC gives exactly the ADC outcome (result, N, Z, C, V) with the operand bitwise inverted.
- R3: CMP (against A) and CPX (against X) set C when the register is greater than or equal to the operand. N and Z come from the register minus the operand. V and the register values are unchanged.
- R4: ANC loads A with A AND operand, sets N and Z from that value, then copies the new N into C.
- R5: ARR forms (A AND operand) shifted right by one, with the incoming C in bit 7, into A. N and Z follow A. The new C is A bit 6, and V is A bit 6 XOR A bit 5.
- R6: AXS writes (A AND X) minus the operand into X, ignoring the incoming C. C is set when (A AND X) is at least the operand, and N and Z follow the new X. A is unchanged.
- R7: BIT leaves A unchanged. It copies operand bit 7 into N and operand bit 6 into V, sets Z when A AND operand is zero, and keeps C.
- R8: AND, ORA and EOR put the logic result into A. LAX loads the operand into both A and X. These four update only N and Z.
- R9: ASL, LSR, ROL and ROR act on the operand and return the shifted byte on both res and mem. C receives the bit shifted out, the rotates feed the old C in at the vacated end, and N and Z follow the byte.
- R10: INC and DEC step the operand by one modulo 256 onto both res and mem, and update only N and Z.
- R11: SLO, SRE, RLA and RRA write the shifted or rotated operand to mem. The shift's carry-out sets C. A becomes A OR, XOR or AND that byte, or A plus that byte plus the rotate's carry-out, with ADC flags for RRA.
- R12: ISC writes operand+1 to mem and subtracts it from A with the SBC rules. DCP writes operand-1 to mem and compares A against it with the CMP rules, leaving A unchanged.
- R13: ALR loads A with (A AND operand) shifted right by one. C is bit 0 of the AND, and N and Z follow A.
- R14: The D flag passes through unchanged and has no effect on any result. When no operation writes mem it equals the operand, and when no operation writes X it equals the incoming X.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation select, a value of the package enumeration |
| a_i | input | 8 | Accumulator value |
| x_i | input | 8 | X index register value |
| opd_i | input | 8 | Operand or memory byte |
| flags_i | input | 5 | Incoming flags {N,V,D,Z,C} |
| res_o | output | 8 | New accumulator or primary result |
| mem_o | output | 8 | Byte to write back to memory |
| x_o | output | 8 | New X value |
| flags_o | output | 5 | Updated flags {N,V,D,Z,C} |

## Verification
The combined operations chain two functions in one evaluation, and the bench targets the points where the two couple.

- RRA: the rotate's carry-out must become the adder's carry-in.
- ISC: the increment must reach the inverted-operand subtraction.
- DCP: the decrement must feed the comparator.

Operand bytes are chosen so that the intermediate byte differs from the raw operand and so that the shifted-out bit changes the final sum. The bench then checks the memory byte, the accumulator and every flag against hand-computed values. A result built from the raw operand, or from the incoming carry, differs on at least one of these outputs.

// File: rtl/alu8_pkg.sv
// Package: shared operation codes, shift modes and flag bit positions
// for the 8-bit accumulator ALU. Assumes a flag vector {N,V,D,Z,C}.
package alu8_pkg;

    localparam int FLAG_W = 5;
    localparam int FN = 4;
    localparam int FV = 3;
    localparam int FD = 2;
    localparam int FZ = 1;
    localparam int FC = 0;

    typedef enum logic [4:0] {
        OP_ADC, OP_SBC, OP_AND, OP_ORA, OP_EOR, OP_LAX,
        OP_CMP, OP_CPX, OP_BIT,
        OP_ASL, OP_LSR, OP_ROL, OP_ROR,
        OP_INC, OP_DEC,
        OP_ANC, OP_ALR, OP_ARR, OP_AXS,
        OP_SLO, OP_SRE, OP_RLA, OP_RRA, OP_ISC, OP_DCP
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT, SH_RIGHT, SH_ROL, SH_ROR
    } shift_e;

endpackage

// File: rtl/alu8_adder.sv
// Module: ripple-carry adder of W bits with carry-in, carry-out and
// two's-complement overflow. Assumes W >= 2. Purely combinational.
module alu8_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);

    logic [W:0] cy;

    assign cy[0] = cin_i;

    // One full-adder cell per bit position.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum_o[i]  = a_i[i] ^ b_i[i] ^ cy[i];
        assign cy[i+1]   = (a_i[i] & b_i[i]) | (cy[i] & (a_i[i] ^ b_i[i]));
    end

    // Carry out of the top cell and signed overflow from the last two carries.
    assign cout_o = cy[W];
    assign ovf_o  = cy[W] ^ cy[W-1];

endmodule

// File: rtl/alu8_shifter.sv
// Module: single-position shifter/rotator. The mode picks a left or
// right shift with zero fill, or a rotate through the carry.
// The bit leaving the byte appears on cout_o. Combinational.
module alu8_shifter
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  shift_e       mode_i,
    input  logic [W-1:0] din_i,
    input  logic         cin_i,
    output logic [W-1:0] dout_o,
    output logic         cout_o
);

    // Select fill bit and direction from the mode.
    always_comb begin
        case (mode_i)
            SH_LEFT: begin
                dout_o = {din_i[W-2:0], 1'b0};
                cout_o = din_i[W-1];
            end
            SH_RIGHT: begin
                dout_o = {1'b0, din_i[W-1:1]};
                cout_o = din_i[0];
            end
            SH_ROL: begin
                dout_o = {din_i[W-2:0], cin_i};
                cout_o = din_i[W-1];
            end
            default: begin
                dout_o = {cin_i, din_i[W-1:1]};
                cout_o = din_i[0];
            end
        endcase
    end

endmodule

// File: rtl/alu8_step.sv
// Module: modulo-2^W increment or decrement by one.
// down_i selects the decrement. Combinational.
module alu8_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] din_i,
    input  logic         down_i,
    output logic [W-1:0] dout_o
);

    localparam logic [W-1:0] ONE = W'(1);

    // Wrap-around step in either direction.
    always_comb begin
        if (down_i) dout_o = din_i - ONE;
        else        dout_o = din_i + ONE;
    end

endmodule

// File: rtl/alu8_core.sv
// Module: combinational ALU for an 8-bit accumulator processor. It covers
// documented arithmetic, logic, shift, compare and step operations, and the
// undocumented fused operations. It returns the new A, the memory
// write-back byte, the new X and the flags {N,V,D,Z,C}.
// Assumptions: binary arithmetic only, the D flag is carried through
// untouched, and unknown operation codes leave every value as it came in.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [4:0]        op_i,
    input  logic [DW-1:0]     a_i,
    input  logic [DW-1:0]     x_i,
    input  logic [DW-1:0]     opd_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [DW-1:0]     res_o,
    output logic [DW-1:0]     mem_o,
    output logic [DW-1:0]     x_o,
    output logic [FLAG_W-1:0] flags_o
);

    localparam int MSB    = DW - 1;
    localparam int ARR_HI = DW - 2;
    localparam int ARR_LO = DW - 3;

    alu_op_e op;
    assign op = alu_op_e'(op_i);

    logic          c_in;
    logic [DW-1:0] a_and_opd;
    logic [DW-1:0] a_and_x;
    assign c_in      = flags_i[FC];
    assign a_and_opd = a_i & opd_i;
    assign a_and_x   = a_i & x_i;

    // ---------------- shifter ----------------
    shift_e        sh_mode;
    logic [DW-1:0] sh_src;
    logic [DW-1:0] sh_out;
    logic          sh_co;

    // Pick the shift direction and source byte for the operation.
    always_comb begin
        case (op)
            OP_LSR, OP_SRE, OP_ALR: sh_mode = SH_RIGHT;
            OP_ROL, OP_RLA:         sh_mode = SH_ROL;
            OP_ROR, OP_RRA, OP_ARR: sh_mode = SH_ROR;
            default:                sh_mode = SH_LEFT;
        endcase
        sh_src = (op == OP_ALR || op == OP_ARR) ? a_and_opd : opd_i;
    end

    alu8_shifter #(.W(DW)) u_shift (
        .mode_i (sh_mode),
        .din_i  (sh_src),
        .cin_i  (c_in),
        .dout_o (sh_out),
        .cout_o (sh_co)
    );

    // ---------------- increment / decrement ----------------
    logic          step_down;
    logic [DW-1:0] step_out;
    assign step_down = (op == OP_DEC) || (op == OP_DCP);

    alu8_step #(.W(DW)) u_step (
        .din_i  (opd_i),
        .down_i (step_down),
        .dout_o (step_out)
    );

    // ---------------- main adder (ADC family) ----------------
    logic [DW-1:0] add_b;
    logic          add_ci;
    logic [DW-1:0] add_sum;
    logic          add_co;
    logic          add_ov;

    // Second adder operand and carry-in for add, subtract and fused ops.
    always_comb begin
        add_ci = c_in;
        case (op)
            OP_SBC:  add_b = ~opd_i;
            OP_ISC:  add_b = ~step_out;
            OP_RRA: begin
                add_b  = sh_out;
                add_ci = sh_co;
            end
            default: add_b = opd_i;
        endcase
    end

    alu8_adder #(.W(DW)) u_add (
        .a_i    (a_i),
        .b_i    (add_b),
        .cin_i  (add_ci),
        .sum_o  (add_sum),
        .cout_o (add_co),
        .ovf_o  (add_ov)
    );

    // ---------------- compare adder (register minus value) ----------------
    logic [DW-1:0] cmp_reg;
    logic [DW-1:0] cmp_val;
    logic [DW-1:0] cmp_diff;
    logic          cmp_co;
    logic          cmp_ov;

    // Choose the register and the subtrahend for compare-style ops.
    always_comb begin
        case (op)
            OP_CPX:  cmp_reg = x_i;
            OP_AXS:  cmp_reg = a_and_x;
            default: cmp_reg = a_i;
        endcase
        cmp_val = (op == OP_DCP) ? step_out : opd_i;
    end

    alu8_adder #(.W(DW)) u_cmp (
        .a_i    (cmp_reg),
        .b_i    (~cmp_val),
        .cin_i  (1'b1),
        .sum_o  (cmp_diff),
        .cout_o (cmp_co),
        .ovf_o  (cmp_ov)
    );

    // ---------------- result and flag selection ----------------
    logic [DW-1:0]     res;
    logic [DW-1:0]     mem;
    logic [DW-1:0]     xr;
    logic [FLAG_W-1:0] fo;

    // Route unit outputs to the result ports and update the defined flags.
    always_comb begin
        res = a_i;
        mem = opd_i;
        xr  = x_i;
        fo  = flags_i;
        case (op)
            OP_ADC, OP_SBC: begin
                res    = add_sum;
                fo[FC] = add_co;
                fo[FV] = add_ov;
                fo[FN] = res[MSB];
                fo[FZ] = (res == '0);
            end
            OP_AND, OP_ORA, OP_EOR: begin
                if (op == OP_AND)      res = a_and_opd;
                else if (op == OP_ORA) res = a_i | opd_i;
                else                   res = a_i ^ opd_i;
                fo[FN] = res[MSB];
                fo[FZ] = (res == '0);
            end
            OP_LAX: begin
                res    = opd_i;
                xr     = opd_i;
                fo[FN] = res[MSB];
                fo[FZ] = (res == '0);
            end
            OP_CMP, OP_CPX: begin
                fo[FC] = cmp_co;
                fo[FN] = cmp_diff[MSB];
                fo[FZ] = (cmp_diff == '0);
            end
            OP_BIT: begin
                fo[FN] = opd_i[MSB];
                fo[FV] = opd_i[ARR_HI];
                fo[FZ] = (a_and_opd == '0);
            end
            OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
                res    = sh_out;
                mem    = sh_out;
                fo[FC] = sh_co;
                fo[FN] = sh_out[MSB];
                fo[FZ] = (sh_out == '0);
            end
            OP_INC, OP_DEC: begin
                res    = step_out;
                mem    = step_out;
                fo[FN] = step_out[MSB];
                fo[FZ] = (step_out == '0);
            end
            OP_ANC: begin
                res    = a_and_opd;
                fo[FN] = res[MSB];
                fo[FZ] = (res == '0);
                fo[FC] = res[MSB];
            end
            OP_ALR: begin
                res    = sh_out;
                fo[FC] = sh_co;
                fo[FN] = res[MSB];
                fo[FZ] = (res == '0);
            end
            OP_ARR: begin
                res    = sh_out;
                fo[FN] = res[MSB];
                fo[FZ] = (res == '0);
                fo[FC] = res[ARR_HI];
                fo[FV] = res[ARR_HI] ^ res[ARR_LO];
            end
            OP_AXS: begin
                xr     = cmp_diff;
                fo[FC] = cmp_co;
                fo[FN] = xr[MSB];
                fo[FZ] = (xr == '0);
            end
            OP_SLO, OP_SRE, OP_RLA: begin
                mem    = sh_out;
                fo[FC] = sh_co;
                if (op == OP_SLO)      res = a_i | sh_out;
                else if (op == OP_SRE) res = a_i ^ sh_out;
                else                   res = a_i & sh_out;
                fo[FN] = res[MSB];
                fo[FZ] = (res == '0);
            end
            OP_RRA: begin
                mem    = sh_out;
                res    = add_sum;
                fo[FC] = add_co;
                fo[FV] = add_ov;
                fo[FN] = res[MSB];
                fo[FZ] = (res == '0);
            end
            OP_ISC: begin
                mem    = step_out;
                res    = add_sum;
                fo[FC] = add_co;
                fo[FV] = add_ov;
                fo[FN] = res[MSB];
                fo[FZ] = (res == '0);
            end
            OP_DCP: begin
                mem    = step_out;
                fo[FC] = cmp_co;
                fo[FN] = cmp_diff[MSB];
                fo[FZ] = (cmp_diff == '0);
            end
            default: ;
        endcase
    end

    assign res_o   = res;
    assign mem_o   = mem;
    assign x_o     = xr;
    assign flags_o = fo;

    // ---------------- assertions ----------------
    logic [DW:0] ref_sum9;
    assign ref_sum9 = {1'b0, a_i} + {1'b0, opd_i} + {{DW{1'b0}}, c_in};

    // Guard arithmetic, compare and fused-op flag rules against port values.
    always_comb begin
        if (op == OP_ADC) begin
            AST_ADD_NINE_BIT: assert ({flags_o[FC], res_o} == ref_sum9) else $error("ADC nine-bit sum mismatch"); // R1
            AST_ADD_SIGN_OVF: assert (flags_o[FV] == ((a_i[MSB] == opd_i[MSB]) && (res_o[MSB] != a_i[MSB]))) else $error("ADC overflow rule broken"); // R1
        end
        if (op == OP_CMP) begin
            AST_CMP_CARRY: assert (flags_o[FC] == (a_i >= opd_i)) else $error("CMP carry wrong"); // R3
        end
        if (op == OP_DCP) begin
            AST_DCP_CARRY: assert (flags_o[FC] == (a_i >= mem_o)) else $error("DCP carry not from stepped byte"); // R12
        end
        if (op == OP_ANC) begin
            AST_ANC_CARRY: assert (flags_o[FC] == flags_o[FN]) else $error("ANC carry differs from N"); // R4
        end
        if (op == OP_ARR) begin
            AST_ARR_OVF: assert (flags_o[FV] == (res_o[ARR_HI] ^ res_o[ARR_LO])) else $error("ARR overflow rule broken"); // R5
        end
        if (op == OP_INC || op == OP_DEC) begin
            AST_STEP_KEEPS_CV: assert (flags_o[FC] == flags_i[FC] && flags_o[FV] == flags_i[FV]) else $error("step touched C or V"); // R10
        end
        AST_DEC_FLAG_PASS: assert (flags_o[FD] == flags_i[FD]) else $error("D flag altered"); // R14
    end

endmodule

// File: tb/sim_alu8_core.sv
// Directed bench for alu8_core: one task per scenario, each checking
// res, mem, x and flags ({N,V,D,Z,C}) against hand-derived values.
module sim_alu8_core;
    import alu8_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op;
    logic [7:0] a, x, opd;
    logic [4:0] fl;
    logic [7:0] res, mem, xo;
    logic [4:0] flo;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_core u0 (
        .op_i    (op),
        .a_i     (a),
        .x_i     (x),
        .opd_i   (opd),
        .flags_i (fl),
        .res_o   (res),
        .mem_o   (mem),
        .x_o     (xo),
        .flags_o (flo)
    );

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp<=%0d", cycles, WATCHDOG);
            report();
        end
    end

    // Drive at a rising edge, sample at the following falling edge.
    task automatic drive(alu_op_e o, logic [7:0] ai, logic [7:0] xi,
                         logic [7:0] di, logic [4:0] fi);
        @(posedge clk);
        op = o; a = ai; x = xi; opd = di; fl = fi;
        @(negedge clk);
    endtask

    task automatic expect4(string tag, logic [7:0] er, logic [7:0] em,
                           logic [7:0] ex, logic [4:0] ef);
        n_checks++;
        if (res !== er) begin n_fail++; $display("FAIL %s res act=%h exp=%h", tag, res, er); end
        n_checks++;
        if (mem !== em) begin n_fail++; $display("FAIL %s mem act=%h exp=%h", tag, mem, em); end
        n_checks++;
        if (xo !== ex) begin n_fail++; $display("FAIL %s x act=%h exp=%h", tag, xo, ex); end
        n_checks++;
        if (flo !== ef) begin n_fail++; $display("FAIL %s flags act=%b exp=%b", tag, flo, ef); end
    endtask

    task automatic t_reset();
        drive(OP_ADC, 8'h00, 8'h00, 8'h00, 5'b00000);
        expect4("reset R1", 8'h00, 8'h00, 8'h00, 5'b00010);
    endtask

    task automatic t_adc();
        drive(OP_ADC, 8'h50, 8'h11, 8'h50, 5'b00000);
        expect4("R1 pos+pos", 8'hA0, 8'h50, 8'h11, 5'b11000);
        drive(OP_ADC, 8'hFF, 8'h00, 8'h01, 5'b00001);
        expect4("R1 carry", 8'h01, 8'h01, 8'h00, 5'b00001);
        drive(OP_ADC, 8'h80, 8'h00, 8'h80, 5'b00000);
        expect4("R1 neg+neg", 8'h00, 8'h80, 8'h00, 5'b01011);
    endtask

    task automatic t_sbc();
        drive(OP_SBC, 8'h50, 8'h00, 8'hB0, 5'b00001);
        expect4("R2 ovf", 8'hA0, 8'hB0, 8'h00, 5'b11000);
        drive(OP_SBC, 8'h05, 8'h00, 8'h03, 5'b00001);
        expect4("R2 no borrow", 8'h02, 8'h03, 8'h00, 5'b00001);
        drive(OP_SBC, 8'h05, 8'h00, 8'h03, 5'b00000);
        expect4("R2 borrow in", 8'h01, 8'h03, 8'h00, 5'b00001);
    endtask

    task automatic t_cmp();
        drive(OP_CMP, 8'h40, 8'h07, 8'h40, 5'b01000);
        expect4("R3 equal", 8'h40, 8'h40, 8'h07, 5'b01011);
        drive(OP_CMP, 8'h10, 8'h00, 8'h20, 5'b00000);
        expect4("R3 less", 8'h10, 8'h20, 8'h00, 5'b10000);
        drive(OP_CPX, 8'h00, 8'h20, 8'h10, 5'b00000);
        expect4("R3 cpx", 8'h00, 8'h10, 8'h20, 5'b00001);
    endtask

    task automatic t_anc_arr_alr();
        drive(OP_ANC, 8'hF0, 8'h00, 8'h8F, 5'b00000);
        expect4("R4 neg", 8'h80, 8'h8F, 8'h00, 5'b10001);
        drive(OP_ANC, 8'h0F, 8'h00, 8'hF0, 5'b00001);
        expect4("R4 zero", 8'h00, 8'hF0, 8'h00, 5'b00010);
        drive(OP_ARR, 8'hFF, 8'h00, 8'hFF, 5'b00001);
        expect4("R5 c in", 8'hFF, 8'hFF, 8'h00, 5'b10001);
        drive(OP_ARR, 8'hFF, 8'h00, 8'h80, 5'b00000);
        expect4("R5 v set", 8'h40, 8'h80, 8'h00, 5'b01001);
        drive(OP_ALR, 8'h03, 8'h00, 8'h01, 5'b00000);
        expect4("R13", 8'h00, 8'h01, 8'h00, 5'b00011);
    endtask

    task automatic t_axs_bit();
        drive(OP_AXS, 8'hF0, 8'h3C, 8'h10, 5'b00000);
        expect4("R6 ge", 8'hF0, 8'h10, 8'h20, 5'b00001);
        drive(OP_AXS, 8'hF0, 8'h3C, 8'h40, 5'b00001);
        expect4("R6 lt c ignored", 8'hF0, 8'h40, 8'hF0, 5'b10000);
        drive(OP_BIT, 8'h01, 8'h00, 8'hC0, 5'b00001);
        expect4("R7", 8'h01, 8'hC0, 8'h00, 5'b11011);
    endtask

    task automatic t_logic();
        drive(OP_AND, 8'hCC, 8'h00, 8'hAA, 5'b00000);
        expect4("R8 and", 8'h88, 8'hAA, 8'h00, 5'b10000);
        drive(OP_ORA, 8'h00, 8'h00, 8'h00, 5'b01001);
        expect4("R8 ora", 8'h00, 8'h00, 8'h00, 5'b01011);
        drive(OP_EOR, 8'hFF, 8'h00, 8'h0F, 5'b00000);
        expect4("R8 eor", 8'hF0, 8'h0F, 8'h00, 5'b10000);
        drive(OP_LAX, 8'h00, 8'h00, 8'h7E, 5'b00000);
        expect4("R8 lax", 8'h7E, 8'h7E, 8'h7E, 5'b00000);
    endtask

    task automatic t_shift_step();
        drive(OP_ASL, 8'h00, 8'h00, 8'h81, 5'b00000);
        expect4("R9 asl", 8'h02, 8'h02, 8'h00, 5'b00001);
        drive(OP_LSR, 8'h00, 8'h00, 8'h01, 5'b00000);
        expect4("R9 lsr", 8'h00, 8'h00, 8'h00, 5'b00011);
        drive(OP_ROL, 8'h00, 8'h00, 8'h80, 5'b00001);
        expect4("R9 rol", 8'h01, 8'h01, 8'h00, 5'b00001);
        drive(OP_ROR, 8'h00, 8'h00, 8'h01, 5'b00001);
        expect4("R9 ror", 8'h80, 8'h80, 8'h00, 5'b10001);
        drive(OP_INC, 8'h00, 8'h00, 8'hFF, 5'b01001);
        expect4("R10 inc wrap", 8'h00, 8'h00, 8'h00, 5'b01011);
        drive(OP_DEC, 8'h00, 8'h00, 8'h00, 5'b00000);
        expect4("R10 dec wrap", 8'hFF, 8'hFF, 8'h00, 5'b10000);
    endtask

    task automatic t_fused();
        drive(OP_SLO, 8'h01, 8'h00, 8'h81, 5'b00000);
        expect4("R11 slo", 8'h03, 8'h02, 8'h00, 5'b00001);
        drive(OP_SRE, 8'hFF, 8'h00, 8'h03, 5'b00000);
        expect4("R11 sre", 8'hFE, 8'h01, 8'h00, 5'b10001);
        drive(OP_RLA, 8'h0F, 8'h00, 8'h88, 5'b00001);
        expect4("R11 rla", 8'h01, 8'h11, 8'h00, 5'b00001);
        drive(OP_RRA, 8'h10, 8'h00, 8'h03, 5'b00000);
        expect4("R11 rra", 8'h12, 8'h01, 8'h00, 5'b00000);
        drive(OP_ISC, 8'h10, 8'h00, 8'h0F, 5'b00001);
        expect4("R12 isc", 8'h00, 8'h10, 8'h00, 5'b00011);
        drive(OP_DCP, 8'h05, 8'h00, 8'h06, 5'b00000);
        expect4("R12 dcp", 8'h05, 8'h05, 8'h00, 5'b00011);
    endtask

    task automatic t_decimal();
        drive(OP_ADC, 8'h09, 8'h00, 8'h01, 5'b00100);
        expect4("R14 binary with D", 8'h0A, 8'h01, 8'h00, 5'b00100);
    endtask

    initial begin
        op = 5'd0; a = '0; x = '0; opd = '0; fl = '0;
        repeat (3) @(posedge clk);
        t_reset();
        rst_n = 1'b1;
        t_adc();
        t_sbc();
        t_cmp();
        t_anc_arr_alr();
        t_axs_bit();
        t_logic();
        t_shift_step();
        t_fused();
        t_decimal();
        done = 1'b1;
        report();
    end

endmodule